// File: doc/BRIEF.md
# Three-Lane Hash Message Injection and Chaining Unit

This unit keeps the three 256-bit chaining values of a three-lane sponge-style hash. For every incoming 256-bit message block it mixes those values with the block to form three permutation inputs. Each input is registered and handed to an external permutation engine. When the engine returns its three results, they become the new chaining values.

Once the block flagged as final has been permuted, the unit runs one more block on its own, using an all-zero message. It then folds the three results of that extra round together with XOR to give the 256-bit digest. After that it returns the chaining values to their starting constants, ready for the next message. Padding and the permutation rounds live outside this unit.

Top module: `msg_inject_chain`

## Requirements
- R1: After reset, `in_ready` is 1 and `perm_start` and `dig_valid` are 0. The chaining values equal the parameters `INIT0`, `INIT1` and `INIT2`.
- R2: Doubling treats a 256-bit value as eight 32-bit words, with word k at bits [32k+31:32k]. Each word moves up one position. The old word 7 becomes the new word 0 and is also XORed into new words 1, 3 and 4.
- R3: With X = double(H0 ^ H1 ^ H2), the lanes are set as follows:
  - lane0 = H0 ^ X ^ M
  - lane1 = H1 ^ X ^ double(M)
  - lane2 = H2 ^ X ^ double(double(M))
- R4: A block is accepted on a clock edge where `in_valid` and `in_ready` are both high. `perm_start` is then high for exactly the next cycle. The lane outputs stay stable until `perm_done` arrives.
- R5: When `perm_done` arrives for an ordinary block, `perm_res0..2` become the chaining values. If that block was not the final one, `in_ready` returns on the following cycle.
- R6: When the final block's `perm_done` arrives, the lanes are loaded with the R3 mix of the returned results and an all-zero message. `perm_start` is high in the next cycle.
- R7: One cycle after the blank block's `perm_done`, `dig_valid` pulses for one cycle. `dig_data` then equals `perm_res0 ^ perm_res1 ^ perm_res2` of that blank block.
- R8: After a digest, the chaining values return to the `INIT` constants, so each message hashes independently of the ones before it.
- R9: `in_ready` is 1 only while idle. Any `in_valid` asserted while busy is ignored.
- R10: A `perm_done` pulse while idle has no effect: no state change, no start, no digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Message block offered |
| in_ready | output | 1 | Unit idle and able to take a block |
| in_data | input | 256 | Message block |
| in_last | input | 1 | Block is the final one of its message |
| perm_start | output | 1 | One-cycle request to the permutation engine |
| perm_lane0 | output | 256 | Lane 0 permutation input |
| perm_lane1 | output | 256 | Lane 1 permutation input |
| perm_lane2 | output | 256 | Lane 2 permutation input |
| perm_done | input | 1 | Permutation results valid (one cycle) |
| perm_res0 | input | 256 | Lane 0 permutation result |
| perm_res1 | input | 256 | Lane 1 permutation result |
| perm_res2 | input | 256 | Lane 2 permutation result |
| dig_valid | output | 1 | One-cycle digest strobe |
| dig_data | output | 256 | Digest |

## Verification
The hardest case to reach is the blank round that follows the final block. It is driven only by the returned results and is never visible as an input, so the bench permutation model checks every lane triple it receives against a queue of expected injections, including the zero-message ones. Replies arrive with latencies that vary from one to four cycles, so the injection that happens on the done edge is exercised at several positions. Stray `in_valid` is driven during busy cycles, and stray `perm_done` pulses are driven while idle, to show that neither disturbs the chaining of the next message.

// File: rtl/msg_inject_chain.sv
module msg_inject_chain #(
  parameter int WORD_W = 32,
  parameter logic [8*WORD_W-1:0] INIT0 = 256'h3c91a7e2_58d0f41b_a6e27c93_0f5b8d14_c2719e6a_7d03b5f8_e84a1c27_19f6d05e,
  parameter logic [8*WORD_W-1:0] INIT1 = 256'h92b4e017_6ac35f8d_0d7e21b9_f53a9c46_2b8f6e03_c4d17a95_7e05b3c8_a1f92d64,
  parameter logic [8*WORD_W-1:0] INIT2 = 256'h5f27c8a1_e0936b4d_b84f12e7_263d9a0c_91c6e57b_4ae8037f_d35b7c29_08a4f6e1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [8*WORD_W-1:0]   in_data,
  input  logic                  in_last,
  output logic                  perm_start,
  output logic [8*WORD_W-1:0]   perm_lane0,
  output logic [8*WORD_W-1:0]   perm_lane1,
  output logic [8*WORD_W-1:0]   perm_lane2,
  input  logic                  perm_done,
  input  logic [8*WORD_W-1:0]   perm_res0,
  input  logic [8*WORD_W-1:0]   perm_res1,
  input  logic [8*WORD_W-1:0]   perm_res2,
  output logic                  dig_valid,
  output logic [8*WORD_W-1:0]   dig_data
);
  localparam int BW = 8 * WORD_W;

  typedef enum logic [2:0] {S_IDLE, S_INJ, S_WAIT, S_BINJ, S_BWAIT, S_OUT} st_t;
  st_t st;

  logic [BW-1:0] h0, h1, h2;
  logic          last_q;
  logic [BW-1:0] s0, s1, s2, mm, x2, m2, m4;

  function automatic logic [BW-1:0] dbl(input logic [BW-1:0] v);
    logic [WORD_W-1:0] top;
    logic [BW-1:0]     r;
    top = v[BW-1 -: WORD_W];
    r = {v[BW-WORD_W-1:0], top};
    r[1*WORD_W +: WORD_W] = r[1*WORD_W +: WORD_W] ^ top;
    r[3*WORD_W +: WORD_W] = r[3*WORD_W +: WORD_W] ^ top;
    r[4*WORD_W +: WORD_W] = r[4*WORD_W +: WORD_W] ^ top;
    return r;
  endfunction

  assign in_ready   = (st == S_IDLE);
  assign perm_start = (st == S_INJ) || (st == S_BINJ);
  assign dig_valid  = (st == S_OUT);

  assign s0 = in_ready ? h0 : perm_res0;
  assign s1 = in_ready ? h1 : perm_res1;
  assign s2 = in_ready ? h2 : perm_res2;
  assign mm = in_ready ? in_data : '0;
  assign x2 = dbl(s0 ^ s1 ^ s2);
  assign m2 = dbl(mm);
  assign m4 = dbl(m2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      h0         <= INIT0;
      h1         <= INIT1;
      h2         <= INIT2;
      last_q     <= 1'b0;
      perm_lane0 <= '0;
      perm_lane1 <= '0;
      perm_lane2 <= '0;
      dig_data   <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          perm_lane0 <= s0 ^ x2 ^ mm;
          perm_lane1 <= s1 ^ x2 ^ m2;
          perm_lane2 <= s2 ^ x2 ^ m4;
          last_q     <= in_last;
          st         <= S_INJ;
        end
        S_INJ:  st <= S_WAIT;
        S_WAIT: if (perm_done) begin
          h0 <= perm_res0;
          h1 <= perm_res1;
          h2 <= perm_res2;
          if (last_q) begin
            perm_lane0 <= s0 ^ x2;
            perm_lane1 <= s1 ^ x2;
            perm_lane2 <= s2 ^ x2;
            st         <= S_BINJ;
          end else begin
            st <= S_IDLE;
          end
        end
        S_BINJ:  st <= S_BWAIT;
        S_BWAIT: if (perm_done) begin
          dig_data <= perm_res0 ^ perm_res1 ^ perm_res2;
          h0       <= INIT0;
          h1       <= INIT1;
          h2       <= INIT2;
          st       <= S_OUT;
        end
        S_OUT:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msg_inject_chain_checker.sv
module msg_inject_chain_checker #(
  parameter int BW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          perm_start,
  input logic          perm_done,
  input logic          dig_valid,
  input logic [BW-1:0] perm_lane0,
  input logic [BW-1:0] perm_lane2
);
  a_r4_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> perm_start);

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    perm_start |=> !perm_start);

  a_r4_lanes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !perm_done) |=> ($stable(perm_lane0) && $stable(perm_lane2)));

  a_r9_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    perm_start |-> !in_ready);

  a_r7_digest_single: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |=> (!dig_valid && in_ready));

  a_r10_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (in_ready && !perm_start && !dig_valid));
endmodule

bind msg_inject_chain msg_inject_chain_checker #(.BW(8*WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .perm_start(perm_start), .perm_done(perm_done), .dig_valid(dig_valid),
  .perm_lane0(perm_lane0), .perm_lane2(perm_lane2)
);

// File: tb/msg_inject_chain_bench.sv
`timescale 1ns/1ps
module msg_inject_chain_bench;
  localparam int B = 256;
  localparam logic [B-1:0] IV0 = 256'h0123_4567_89ab_cdef_fedc_ba98_7654_3210_0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0;
  localparam logic [B-1:0] IV1 = 256'hdead_beef_1357_9bdf_2468_ace0_c001_d00d_8badf00d_0ddba11_5ca1ab1e_feedface;
  localparam logic [B-1:0] IV2 = 256'h7a7a_5151_e3e3_0c0c_9292_4848_b6b6_2727_13579bdf_2468ace0_f0e1d2c3_b4a59687;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n = 0, in_valid = 0, in_last = 0;
  logic [B-1:0] in_data = '0;
  logic in_ready, perm_start, dig_valid;
  logic [B-1:0] perm_lane0, perm_lane1, perm_lane2, dig_data;
  logic mdone = 0, jdone = 0;
  logic [B-1:0] mres0 = '0, mres1 = '0, mres2 = '0, jres = '0;
  logic perm_done;
  logic [B-1:0] perm_res0, perm_res1, perm_res2;

  assign perm_done = mdone | jdone;
  assign perm_res0 = jdone ? jres : mres0;
  assign perm_res1 = jdone ? ~jres : mres1;
  assign perm_res2 = jdone ? {jres[127:0], jres[255:128]} : mres2;

  msg_inject_chain #(.WORD_W(32), .INIT0(IV0), .INIT1(IV1), .INIT2(IV2)) u_msg_inject_chain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .perm_start(perm_start),
    .perm_lane0(perm_lane0), .perm_lane1(perm_lane1), .perm_lane2(perm_lane2),
    .perm_done(perm_done), .perm_res0(perm_res0), .perm_res1(perm_res1),
    .perm_res2(perm_res2), .dig_valid(dig_valid), .dig_data(dig_data));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [B-1:0]   exp_dig_q[$];
  logic [3*B-1:0] exp_lane_q[$];
  bit             exp_blank_q[$];

  task automatic chk(input bit ok, input string tag, input logic [3*B-1:0] act, input logic [3*B-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [B-1:0] dbl(input logic [B-1:0] v);
    logic [B-1:0] r;
    for (int k = 0; k < 8; k++)
      r[32*k +: 32] = (k == 0) ? v[255:224] : v[32*(k-1) +: 32];
    for (int k = 0; k < 8; k++)
      if (k == 1 || k == 3 || k == 4) r[32*k +: 32] = r[32*k +: 32] ^ v[255:224];
    return r;
  endfunction

  function automatic logic [3*B-1:0] mix(input logic [B-1:0] a0, a1, a2, m);
    logic [B-1:0] x;
    x = dbl(a0 ^ a1 ^ a2);
    return {a0 ^ x ^ m, a1 ^ x ^ dbl(m), a2 ^ x ^ dbl(dbl(m))};
  endfunction

  function automatic logic [B-1:0] fperm(input logic [B-1:0] x, input int k);
    int s;
    s = 5 + 11 * k;
    return ((x << s) | (x >> (B - s))) ^ (x >> 3) ^ {8{32'h9e3779b9 + k}};
  endfunction

  int lat_cnt = 0, cd = 0;
  bit busy = 0;
  always @(negedge clk) begin
    mdone = 0;
    if (busy) begin
      if (cd == 1) begin
        mdone = 1;
        mres0 = fperm(perm_lane0, 0);
        mres1 = fperm(perm_lane1, 1);
        mres2 = fperm(perm_lane2, 2);
        busy = 0;
      end else cd--;
    end
    if (rst_n && perm_start) begin
      if (exp_lane_q.size() == 0) chk(0, "R4 unexpected start", 1, 0);
      else begin
        logic [3*B-1:0] e;
        bit bl;
        e = exp_lane_q.pop_front();
        bl = exp_blank_q.pop_front();
        chk({perm_lane0, perm_lane1, perm_lane2} === e,
            bl ? "R6 blank lanes" : "R3 R2 lanes", {perm_lane0, perm_lane1, perm_lane2}, e);
      end
      cd = 1 + (lat_cnt % 4);
      lat_cnt++;
      busy = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && dig_valid) begin
      if (exp_dig_q.size() == 0) chk(0, "R7 unexpected digest", {512'b0, dig_data}, 0);
      else begin
        logic [B-1:0] e;
        e = exp_dig_q.pop_front();
        chk(dig_data === e, "R7 R5 R8 digest", {512'b0, dig_data}, {512'b0, e});
      end
    end
  end

  task automatic send_msg(input logic [B-1:0] blk[4], input int n);
    logic [B-1:0] h0, h1, h2;
    logic [3*B-1:0] l;
    h0 = IV0; h1 = IV1; h2 = IV2;
    for (int i = 0; i <= n; i++) begin
      l = mix(h0, h1, h2, (i < n) ? blk[i] : '0);
      exp_lane_q.push_back(l);
      exp_blank_q.push_back(i == n);
      h0 = fperm(l[3*B-1:2*B], 0);
      h1 = fperm(l[2*B-1:B], 1);
      h2 = fperm(l[B-1:0], 2);
    end
    exp_dig_q.push_back(h0 ^ h1 ^ h2);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_data = blk[i]; in_last = (i == n - 1);
      @(negedge clk);
      chk(perm_start === 1'b1, "R4 start after accept", {767'b0, perm_start}, 1);
      in_data = ~blk[i]; in_last = 1;
      chk(in_ready === 1'b0, "R9 busy ready low", {767'b0, in_ready}, 0);
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=digest");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [B-1:0] blk[4];
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R1 ready", {767'b0, in_ready}, 1);
    chk(perm_start === 1'b0, "R1 start", {767'b0, perm_start}, 0);
    chk(dig_valid === 1'b0, "R1 digest", {767'b0, dig_valid}, 0);
    rst_n = 1;

    blk[0] = 256'h6162_6380_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000;
    blk[1] = '0; blk[2] = '0; blk[3] = '0;
    send_msg(blk, 1);

    blk[0] = {8{32'h1111_2222}}; blk[1] = {8{32'h8000_0001}}; blk[2] = {32{8'hc3}};
    send_msg(blk, 3);

    blk[0] = '0;
    send_msg(blk, 1);

    while (!in_ready || exp_dig_q.size() != 0) @(negedge clk);
    @(negedge clk);
    jdone = 1; jres = {4{64'h0bad_cafe_1234_5678}};
    @(negedge clk);
    jdone = 0;
    chk(in_ready === 1'b1, "R10 stray done ready", {767'b0, in_ready}, 1);
    chk(perm_start === 1'b0, "R10 stray done start", {767'b0, perm_start}, 0);
    chk(dig_valid === 1'b0, "R10 stray done digest", {767'b0, dig_valid}, 0);

    blk[0] = {8{32'hffff_0000}}; blk[1] = {8{32'h0000_ffff}};
    send_msg(blk, 2);

    blk[0] = '1;
    send_msg(blk, 1);

    while (exp_dig_q.size() != 0 || exp_lane_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule